// File: doc/BRIEF.md
# Reorder buffer with branch kill

This block keeps decoded instructions in program order between decode and retirement. Each instruction claims a slot at the tail and receives a tag, the slot index. Execution units later report results against that tag in any order. The block retires results to the register file one at a time from the oldest slot, and only once that slot has finished.

Several unresolved branches may sit in the buffer together and may resolve in any order. A mispredicted branch removes only the slots allocated after it. The branch and everything older stay in place, and fetch is redirected to the corrected PC.

A result that carries an exception flag is not acted on while the slot is still young. When that slot becomes the oldest, nothing is retired from it. The whole buffer is emptied and fetch is redirected to a fixed handler address.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, commit_valid is 0 and redir_valid is 0.
- R2: Tags are handed out in program order. alloc_tag shows the index the next allocation will receive. It steps by one per accepted allocation and wraps from 15 to 0 with the default depth of 16.
- R3: With 16 live slots, alloc_ready is 0 and an asserted alloc_valid is ignored: alloc_tag does not move. Once the oldest slot retires, allocation resumes at the same tag.
- R4: Retirement is strictly in order. commit_valid stays 0 while the oldest slot has not completed, even when younger slots have.
- R5: When commit_valid is 1, commit_dest and commit_data carry the destination given at allocation and the result given at completion for the oldest slot.
- R6: At most one slot retires per cycle. Slots that complete early retire on successive cycles.
- R7: A mispredict on tag T kills every slot younger than T, and the next allocation receives tag T+1. Completions aimed at killed slots are dropped, so a reused slot does not retire until it is completed anew.
- R8: One cycle after a mispredict is accepted, redir_valid is 1, redir_trap is 0 and redir_pc equals the mispredict PC. redir_valid is 0 on the following cycle when nothing new occurs.
- R9: When a mispredict and an allocation arrive in the same cycle, the allocation is discarded.
- R10: When the oldest slot has completed with its exception flag set, it does not retire. All slots are killed. One cycle later, redir_valid is 1, redir_trap is 1 and redir_pc equals the HANDLER_PC parameter, and the next allocation reuses the faulting tag.
- R11: An exception flag on a slot that is not the oldest causes no redirect and no retirement until the slot reaches the head.
- R12: When an exception is taken at the head in the same cycle as a mispredict, the exception wins: redir_trap is 1 and redir_pc is HANDLER_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request a slot for a decoded instruction |
| alloc_dest | input | 5 | Destination register of the new instruction |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | 4 | Tag the next allocation receives |
| cmpl_valid | input | 1 | A result is reported |
| cmpl_tag | input | 4 | Slot the result belongs to |
| cmpl_data | input | 32 | Result value |
| cmpl_exc | input | 1 | Result raised an exception |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_dest | output | 5 | Register written by the retiring slot |
| commit_data | output | 32 | Value written by the retiring slot |
| mispredict_valid | input | 1 | A branch was found mispredicted |
| mispredict_tag | input | 4 | Tag of the mispredicted branch |
| mispredict_pc | input | 32 | Corrected fetch address |
| redir_valid | output | 1 | Fetch redirect, one cycle after the cause |
| redir_pc | output | 32 | Redirect target |
| redir_trap | output | 1 | 1 for exception redirect, 0 for mispredict |

## Verification
The bench drives a mispredict in the same cycle as an allocation request. It then checks that the next tag offered is the one just after the branch and that none of the killed slots ever retire. It also raises a mispredict in the very cycle an exception is taken at the head, and checks that the redirect carries the handler address with the trap flag set. Scrambled completion orders from a vector table show results draining one per cycle in program order.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 16;
    localparam int IDX_W     = $clog2(ROB_DEPTH);
    localparam int PTR_W     = IDX_W + 1;
    localparam int XLEN      = 32;
    localparam int REG_W     = 5;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic {
        CAUSE_BRANCH = 1'b0,
        CAUSE_TRAP   = 1'b1
    } redir_cause_e;

    typedef struct packed {
        logic             done;
        logic             exc;
        logic [REG_W-1:0] dest;
        logic [XLEN-1:0]  data;
    } slot_t;

    // distance of a slot from the oldest slot, in program order
    function automatic ptr_t age_of(idx_t slot, idx_t oldest);
        idx_t d;
        d = slot - oldest;
        return ptr_t'(d);
    endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc_req,
    input  logic            flush_req,
    input  idx_t            flush_tag,
    input  logic [XLEN-1:0] flush_pc,
    input  logic            head_done,
    input  logic            head_exc,
    output ptr_t            head_ptr,
    output ptr_t            tail_ptr,
    output ptr_t            count,
    output logic            full,
    output logic            do_alloc,
    output logic            do_commit,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output redir_cause_e    redir_cause
);
    ptr_t head_q, tail_q;
    logic empty, do_trap, do_flush;

    assign count     = tail_q - head_q;
    assign empty     = (count == '0);
    assign full      = (count == ptr_t'(ROB_DEPTH));
    assign do_commit = !empty && head_done && !head_exc;
    assign do_trap   = !empty && head_done && head_exc;
    assign do_flush  = flush_req && !do_trap;
    assign do_alloc  = alloc_req && !full && !do_flush && !do_trap;
    assign head_ptr  = head_q;
    assign tail_ptr  = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q      <= '0;
            tail_q      <= '0;
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_cause <= CAUSE_BRANCH;
        end else begin
            if (do_commit)
                head_q <= head_q + ptr_t'(1);
            if (do_trap)
                tail_q <= head_q;
            else if (do_flush)
                tail_q <= head_q + age_of(flush_tag, head_q[IDX_W-1:0]) + ptr_t'(1);
            else if (do_alloc)
                tail_q <= tail_q + ptr_t'(1);
            redir_valid <= do_trap || do_flush;
            redir_pc    <= do_trap ? HANDLER_PC : flush_pc;
            redir_cause <= do_trap ? CAUSE_TRAP : CAUSE_BRANCH;
        end
    end

    always_comb begin
        if (!rst) p_count_bound_r3: assert (count <= ptr_t'(ROB_DEPTH));
    end

    p_head_step_r6: assert property (@(posedge clk) disable iff (rst)
        do_commit |=> head_q == $past(head_q) + ptr_t'(1));

    p_flush_tail_r7: assert property (@(posedge clk) disable iff (rst)
        do_flush |=> tail_q[IDX_W-1:0] == $past(flush_tag) + idx_t'(1));

    p_trap_empties_r10: assert property (@(posedge clk) disable iff (rst)
        do_trap |=> (tail_q == head_q) && redir_cause == CAUSE_TRAP);
endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_we,
    input  idx_t             alloc_idx,
    input  logic [REG_W-1:0] alloc_dest,
    input  logic             cmpl_we,
    input  idx_t             cmpl_idx,
    input  logic [XLEN-1:0]  cmpl_data,
    input  logic             cmpl_exc,
    input  idx_t             head_idx,
    input  ptr_t             count,
    output slot_t            head_slot
);
    slot_t slots [ROB_DEPTH];
    logic [ROB_DEPTH-1:0] live;

    for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_live
        assign live[i] = age_of(idx_t'(i), head_idx) < count;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROB_DEPTH; i++) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (alloc_we && alloc_idx == idx_t'(i)) begin
                slots[i] <= '{done: 1'b0, exc: 1'b0, dest: alloc_dest, data: '0};
            end else if (cmpl_we && cmpl_idx == idx_t'(i) && live[i]) begin
                slots[i].done <= 1'b1;
                slots[i].exc  <= cmpl_exc;
                slots[i].data <= cmpl_data;
            end
        end
    end

    assign head_slot = slots[head_idx];

    p_fresh_slot_r7: assert property (@(posedge clk) disable iff (rst)
        alloc_we |=> !slots[$past(alloc_idx)].done);
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic [REG_W-1:0] alloc_dest,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_tag,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_tag,
    input  logic [XLEN-1:0]  cmpl_data,
    input  logic             cmpl_exc,
    output logic             commit_valid,
    output logic [REG_W-1:0] commit_dest,
    output logic [XLEN-1:0]  commit_data,
    input  logic             mispredict_valid,
    input  logic [IDX_W-1:0] mispredict_tag,
    input  logic [XLEN-1:0]  mispredict_pc,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_pc,
    output logic             redir_trap
);
    ptr_t         head_ptr, tail_ptr, count;
    logic         full, do_alloc, do_commit;
    slot_t        head_slot;
    redir_cause_e cause;

    rob_ptrs #(.HANDLER_PC(HANDLER_PC)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (alloc_valid),
        .flush_req  (mispredict_valid),
        .flush_tag  (mispredict_tag),
        .flush_pc   (mispredict_pc),
        .head_done  (head_slot.done),
        .head_exc   (head_slot.exc),
        .head_ptr   (head_ptr),
        .tail_ptr   (tail_ptr),
        .count      (count),
        .full       (full),
        .do_alloc   (do_alloc),
        .do_commit  (do_commit),
        .redir_valid(redir_valid),
        .redir_pc   (redir_pc),
        .redir_cause(cause)
    );

    rob_store u_store (
        .clk       (clk),
        .rst       (rst),
        .alloc_we  (do_alloc),
        .alloc_idx (tail_ptr[IDX_W-1:0]),
        .alloc_dest(alloc_dest),
        .cmpl_we   (cmpl_valid),
        .cmpl_idx  (cmpl_tag),
        .cmpl_data (cmpl_data),
        .cmpl_exc  (cmpl_exc),
        .head_idx  (head_ptr[IDX_W-1:0]),
        .count     (count),
        .head_slot (head_slot)
    );

    assign alloc_ready  = !full;
    assign alloc_tag    = tail_ptr[IDX_W-1:0];
    assign commit_valid = do_commit;
    assign commit_dest  = head_slot.dest;
    assign commit_data  = head_slot.data;
    assign redir_trap   = (cause == CAUSE_TRAP);

    p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_ready && !mispredict_valid) |=> $stable(alloc_tag));

    p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
        mispredict_valid |=> redir_valid);

    p_no_commit_empty_r4: assert property (@(posedge clk) disable iff (rst)
        redir_trap && redir_valid |-> !commit_valid);
endmodule

// File: tb/tb_rob_core.sv
module tb_rob_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_valid;
    logic [4:0]  alloc_dest;
    logic        alloc_ready;
    logic [3:0]  alloc_tag;
    logic        cmpl_valid;
    logic [3:0]  cmpl_tag;
    logic [31:0] cmpl_data;
    logic        cmpl_exc;
    logic        commit_valid;
    logic [4:0]  commit_dest;
    logic [31:0] commit_data;
    logic        mispredict_valid;
    logic [3:0]  mispredict_tag;
    logic [31:0] mispredict_pc;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic        redir_trap;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_core #(.HANDLER_PC(HANDLER)) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .cmpl_data(cmpl_data), .cmpl_exc(cmpl_exc),
        .commit_valid(commit_valid), .commit_dest(commit_dest),
        .commit_data(commit_data),
        .mispredict_valid(mispredict_valid), .mispredict_tag(mispredict_tag),
        .mispredict_pc(mispredict_pc),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_trap(redir_trap)
    );

    // {completed tag, expected commit_valid, expected retiring index}
    localparam logic [8:0] VEC [8] = '{
        {4'd2, 1'b0, 4'd0}, {4'd0, 1'b1, 4'd0}, {4'd1, 1'b1, 4'd1},
        {4'd3, 1'b1, 4'd3}, {4'd5, 1'b0, 4'd0}, {4'd4, 1'b1, 4'd4},
        {4'd7, 1'b0, 4'd0}, {4'd6, 1'b1, 4'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic alloc(input logic [4:0] dest, input logic [3:0] exp_tag, input string req);
        @(negedge clk);
        chk(req, {28'd0, alloc_tag}, {28'd0, exp_tag});
        alloc_valid = 1'b1;
        alloc_dest  = dest;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic complete(input logic [3:0] tag, input logic [31:0] data, input logic exc);
        @(negedge clk);
        cmpl_valid = 1'b1;
        cmpl_tag   = tag;
        cmpl_data  = data;
        cmpl_exc   = exc;
        @(posedge clk); #1;
        cmpl_valid = 1'b0;
        cmpl_exc   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        alloc_valid = 0; alloc_dest = '0;
        cmpl_valid = 0; cmpl_tag = '0; cmpl_data = '0; cmpl_exc = 0;
        mispredict_valid = 0; mispredict_tag = '0; mispredict_pc = '0;
        do_reset();

        // R1 reset state
        @(negedge clk);
        chk("R1 ready", {31'd0, alloc_ready}, 32'd1);
        chk("R1 tag", {28'd0, alloc_tag}, 32'd0);
        chk("R1 commit", {31'd0, commit_valid}, 32'd0);
        chk("R1 redirect", {31'd0, redir_valid}, 32'd0);

        // R2 allocate eight in order
        for (int k = 0; k < 8; k++) alloc(5'(k + 8), 4'(k), "R2 tag order");

        // R4 R5 R6 scrambled completion order from the table
        for (int i = 0; i < 8; i++) begin
            complete(VEC[i][8:5], 32'd100 + 32'(VEC[i][8:5]), 1'b0);
            @(negedge clk);
            chk("R4 in-order commit", {31'd0, commit_valid}, {31'd0, VEC[i][4]});
            if (VEC[i][4]) begin
                chk("R5 dest", {27'd0, commit_dest}, 32'(VEC[i][3:0]) + 32'd8);
                chk("R5 data", commit_data, 32'd100 + 32'(VEC[i][3:0]));
            end
        end
        @(negedge clk);
        chk("R6 last commit", {31'd0, commit_valid}, 32'd1);
        chk("R6 last dest", {27'd0, commit_dest}, 32'd15);
        @(negedge clk);
        chk("R6 drained", {31'd0, commit_valid}, 32'd0);
        chk("R2 tag after drain", {28'd0, alloc_tag}, 32'd8);

        // R3 full buffer, with R2 wrap
        for (int k = 0; k < 16; k++) alloc(5'(k), 4'(8 + k), "R2 wrap");
        @(negedge clk);
        chk("R3 not ready when full", {31'd0, alloc_ready}, 32'd0);
        alloc_valid = 1'b1; alloc_dest = 5'd31;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
        @(negedge clk);
        chk("R3 tag held", {28'd0, alloc_tag}, 32'd8);
        chk("R3 still full", {31'd0, alloc_ready}, 32'd0);
        complete(4'd8, 32'd55, 1'b0);
        @(negedge clk);
        chk("R3 head commit", {31'd0, commit_valid}, 32'd1);
        chk("R3 head dest", {27'd0, commit_dest}, 32'd0);
        @(negedge clk);
        chk("R3 ready again", {31'd0, alloc_ready}, 32'd1);
        chk("R3 resume tag", {28'd0, alloc_tag}, 32'd8);
        alloc(5'd9, 4'd8, "R3 refill tag");
        @(negedge clk);
        chk("R3 full again", {31'd0, alloc_ready}, 32'd0);

        // R7 R8 R9 mispredict with a colliding allocation
        do_reset();
        for (int k = 0; k < 6; k++) alloc(5'(k + 1), 4'(k), "R2 tag before flush");
        @(negedge clk);
        mispredict_valid = 1'b1; mispredict_tag = 4'd2; mispredict_pc = 32'h400;
        alloc_valid = 1'b1; alloc_dest = 5'd31;
        @(posedge clk); #1;
        mispredict_valid = 1'b0; alloc_valid = 1'b0;
        @(negedge clk);
        chk("R8 redirect valid", {31'd0, redir_valid}, 32'd1);
        chk("R8 redirect kind", {31'd0, redir_trap}, 32'd0);
        chk("R8 redirect pc", redir_pc, 32'h400);
        chk("R9 alloc dropped, R7 tail", {28'd0, alloc_tag}, 32'd3);
        @(negedge clk);
        chk("R8 redirect pulse", {31'd0, redir_valid}, 32'd0);
        complete(4'd3, 32'd1, 1'b0);
        complete(4'd4, 32'd2, 1'b0);
        complete(4'd5, 32'd3, 1'b0);
        alloc(5'd20, 4'd3, "R7 reuse tag");
        complete(4'd0, 32'd10, 1'b0);
        @(negedge clk);
        chk("R7 older commit 0", {27'd0, commit_dest}, 32'd1);
        complete(4'd1, 32'd11, 1'b0);
        @(negedge clk);
        chk("R7 older commit 1", {27'd0, commit_dest}, 32'd2);
        complete(4'd2, 32'd12, 1'b0);
        @(negedge clk);
        chk("R7 branch commits", {27'd0, commit_dest}, 32'd3);
        chk("R7 branch commit valid", {31'd0, commit_valid}, 32'd1);
        @(negedge clk);
        chk("R7 killed completion dropped", {31'd0, commit_valid}, 32'd0);
        complete(4'd3, 32'd77, 1'b0);
        @(negedge clk);
        chk("R7 new slot commit", {31'd0, commit_valid}, 32'd1);
        chk("R7 new slot dest", {27'd0, commit_dest}, 32'd20);
        chk("R7 new slot data", commit_data, 32'd77);

        // R10 R11 R12 precise exception
        do_reset();
        for (int k = 0; k < 3; k++) alloc(5'(k + 1), 4'(k), "R2 tag before trap");
        complete(4'd1, 32'hBAD, 1'b1);
        @(negedge clk);
        chk("R11 no early redirect", {31'd0, redir_valid}, 32'd0);
        chk("R11 no commit", {31'd0, commit_valid}, 32'd0);
        complete(4'd2, 32'd22, 1'b0);
        complete(4'd0, 32'd20, 1'b0);
        @(negedge clk);
        chk("R11 older commits", {31'd0, commit_valid}, 32'd1);
        chk("R11 older dest", {27'd0, commit_dest}, 32'd1);
        chk("R11 still no redirect", {31'd0, redir_valid}, 32'd0);
        @(negedge clk);
        chk("R10 faulting slot not committed", {31'd0, commit_valid}, 32'd0);
        mispredict_valid = 1'b1; mispredict_tag = 4'd2; mispredict_pc = 32'h777;
        @(posedge clk); #1;
        mispredict_valid = 1'b0;
        @(negedge clk);
        chk("R10 redirect valid", {31'd0, redir_valid}, 32'd1);
        chk("R12 trap wins kind", {31'd0, redir_trap}, 32'd1);
        chk("R12 trap wins pc", redir_pc, HANDLER);
        chk("R10 tag reused", {28'd0, alloc_tag}, 32'd1);
        chk("R10 ready", {31'd0, alloc_ready}, 32'd1);
        chk("R10 no commit", {31'd0, commit_valid}, 32'd0);
        @(negedge clk);
        chk("R10 younger killed", {31'd0, commit_valid}, 32'd0);
        chk("R10 redirect pulse", {31'd0, redir_valid}, 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule